// File: doc/BRIEF.md
# Serial Command Front End for a Dual-Channel 12-bit DAC

This block is the digital input stage of a two-channel DAC. A fast system clock oversamples three serial pins: an active-low frame strobe, a serial clock and serial data. It assembles 16-bit command words and applies them to two channels. Each channel has a holding register and a live output register. The live registers drive the two 12-bit codes that go to the converters. An active-low load pin moves the holding registers into the live registers. When the pin is held low, every accepted word also updates the live registers.

The block powers up in chain mode. In this mode it keeps shifting while the strobe is low and passes bits that overflow the 16-bit register to a serial output, so several parts can be cascaded. The final 16 bits are applied when the strobe goes high. One command moves the block into solo mode, and it stays there until reset. In solo mode a bit counter applies the word on the 16th falling clock. Clocks after that are ignored until the strobe falls again. A strobe that goes high part-way through a word discards it.

The serial clock must run at no more than a quarter of the system clock rate.

Top module: `dac_serial_front`

## Requirements
- R1: A word is 16 bits, sent most significant bit first. Bits [15:12] are the command and bits [11:0] are the data. Data is sampled on falling serial clock edges and only while the strobe is low.
- R2: After reset both codes are 0, the serial output is 0 and the block is in chain mode.
- R3: In chain mode the last 16 bits received are applied when the strobe rises. A frame with fewer than 16 bits changes nothing.
- R4: In chain mode the shift register is cleared when the strobe falls. Its most significant bit is presented on the serial output after each rising serial clock. The first 16 output bits of a frame are therefore 0, and the bits that follow are the frame's opening bits.
- R5: Command 1001 switches to solo mode, which lasts until reset. In solo mode the serial output stays 0.
- R6: In solo mode the word is applied on the 16th falling serial clock, while the strobe is still low. Further clocks in the same frame are ignored. A strobe rise before the 16th bit discards the word.
- R7: Commands 0001 and 0100 write the data into both registers of channel A and of channel B respectively, whatever the level of the load pin.
- R8: Commands 0011 and 0110 write the holding register of channel A and of channel B. Command 1000 writes both holding registers. With the load pin high, the codes do not change.
- R9: Command 0111 copies both holding registers into the live registers.
- R10: Command 1011 sets all four registers to 0. Command 1100 sets all four to 0x800.
- R11: Commands 0000, 0010, 0101, 1010, 1101, 1110 and 1111 change neither code.
- R12: A falling edge on the load pin copies both holding registers into the live registers. If that edge falls in the same cycle as an applied word, the copy uses the holding values written by that word.
- R13: While the load pin is held low, every applied word also copies both holding registers, including the values just written, into the live registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_ni | input | 1 | Active-low frame strobe |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| load_ni | input | 1 | Active-low load pin |
| sdo_o | output | 1 | Serial data out for chaining |
| code_a_o | output | 12 | Channel A live code |
| code_b_o | output | 12 | Channel B live code |

## Verification
Two events can fall in the same cycle: a falling edge on the load pin and the application of a word that writes a holding register. The bench provokes this by driving the load pin low in the same system clock cycle as the strobe rise that ends a chain frame. Both pins pass through synchronisers of equal depth, so their edges are detected together. The result is correct only if the live code shows the value that word wrote, not the stale holding value.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int CMD_W  = 4;
  localparam int DATA_W = 12;

  localparam logic [CMD_W-1:0] CMD_LU_A  = 4'h1;
  localparam logic [CMD_W-1:0] CMD_LI_A  = 4'h3;
  localparam logic [CMD_W-1:0] CMD_LU_B  = 4'h4;
  localparam logic [CMD_W-1:0] CMD_LI_B  = 4'h6;
  localparam logic [CMD_W-1:0] CMD_UPD   = 4'h7;
  localparam logic [CMD_W-1:0] CMD_LI_AB = 4'h8;
  localparam logic [CMD_W-1:0] CMD_SOLO  = 4'h9;
  localparam logic [CMD_W-1:0] CMD_CLR0  = 4'hB;
  localparam logic [CMD_W-1:0] CMD_CLRM  = 4'hC;

  typedef enum logic {MODE_CHAIN = 1'b0, MODE_SOLO = 1'b1} mode_e;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int          N       = 4,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[g]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= q_o;
  end

  assign rise_o = q_o & ~prev_q;
  assign fall_o = ~q_o & prev_q;
endmodule

// File: rtl/dacfe_frame.sv
module dacfe_frame
  import dacfe_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_lvl_i,
  input  logic              frame_rise_i,
  input  logic              frame_fall_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sdi_i,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o,
  output logic              solo_o,
  output logic              sdo_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sreg_q, shifted;
  logic [CNT_W-1:0]  cnt_q;
  mode_e             mode_q;
  logic              shift_en;

  assign shifted  = {sreg_q[WORD_W-2:0], sdi_i};
  assign shift_en = !frame_lvl_i && sclk_fall_i && !frame_fall_i &&
                    (mode_q == MODE_CHAIN || cnt_q != CNT_FULL);

  always_comb begin
    if (mode_q == MODE_SOLO) begin
      commit_o = shift_en && (cnt_q == CNT_LAST);
      word_o   = shifted;
    end else begin
      commit_o = frame_rise_i && (cnt_q == CNT_FULL);
      word_o   = sreg_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      mode_q <= MODE_CHAIN;
      sdo_o  <= 1'b0;
    end else begin
      if (frame_fall_i) begin
        sreg_q <= '0;
        cnt_q  <= '0;
      end else if (shift_en) begin
        sreg_q <= shifted;
        if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
      end
      if (commit_o && word_o[WORD_W-1 -: CMD_W] == CMD_SOLO) mode_q <= MODE_SOLO;
      if (mode_q == MODE_SOLO)                    sdo_o <= 1'b0;
      else if (!frame_lvl_i && sclk_rise_i)       sdo_o <= sreg_q[WORD_W-1];
    end
  end

  assign solo_o = (mode_q == MODE_SOLO);
endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              load_low_i,
  input  logic              load_fall_i,
  output logic [DATA_W-1:0] in_a_o,
  output logic [DATA_W-1:0] in_b_o,
  output logic [DATA_W-1:0] code_a_o,
  output logic [DATA_W-1:0] code_b_o
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] nx_a, nx_b;
  logic              dir_a, dir_b, upd_all;

  always_comb begin
    nx_a    = in_a_o;
    nx_b    = in_b_o;
    dir_a   = 1'b0;
    dir_b   = 1'b0;
    upd_all = load_fall_i || (commit_i && load_low_i);
    if (commit_i) begin
      case (cmd_i)
        CMD_LU_A:  begin nx_a = data_i; dir_a = 1'b1; end
        CMD_LI_A:  nx_a = data_i;
        CMD_LU_B:  begin nx_b = data_i; dir_b = 1'b1; end
        CMD_LI_B:  nx_b = data_i;
        CMD_LI_AB: begin nx_a = data_i; nx_b = data_i; end
        CMD_UPD:   upd_all = 1'b1;
        CMD_CLR0:  begin nx_a = '0;  nx_b = '0;  dir_a = 1'b1; dir_b = 1'b1; end
        CMD_CLRM:  begin nx_a = MID; nx_b = MID; dir_a = 1'b1; dir_b = 1'b1; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_a_o   <= '0;
      in_b_o   <= '0;
      code_a_o <= '0;
      code_b_o <= '0;
    end else begin
      in_a_o <= nx_a;
      in_b_o <= nx_b;
      if (upd_all || dir_a) code_a_o <= nx_a;
      if (upd_all || dir_b) code_b_o <= nx_b;
    end
  end
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dacfe_pkg::*;
#(
  parameter int DATA_W      = dacfe_pkg::DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              load_ni,
  output logic              sdo_o,
  output logic [DATA_W-1:0] code_a_o,
  output logic [DATA_W-1:0] code_b_o
);
  localparam int WORD_W = CMD_W + DATA_W;

  // bit order: load, sdi, sclk, frame
  logic [3:0]        pin_q, pin_rise, pin_fall;
  logic              commit, solo, unused_ok;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] in_a, in_b;

  dacfe_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk_i, .rst_ni,
    .d_i   ({load_ni, sdi_i, sclk_i, frame_ni}),
    .q_o   (pin_q),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  dacfe_frame #(.WORD_W(WORD_W)) u_frame (
    .clk_i, .rst_ni,
    .frame_lvl_i (pin_q[0]),
    .frame_rise_i(pin_rise[0]),
    .frame_fall_i(pin_fall[0]),
    .sclk_rise_i (pin_rise[1]),
    .sclk_fall_i (pin_fall[1]),
    .sdi_i       (pin_q[2]),
    .commit_o    (commit),
    .word_o      (word),
    .solo_o      (solo),
    .sdo_o       (sdo_o)
  );

  dacfe_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .commit_i   (commit),
    .cmd_i      (word[WORD_W-1 -: CMD_W]),
    .data_i     (word[DATA_W-1:0]),
    .load_low_i (!pin_q[3]),
    .load_fall_i(pin_fall[3]),
    .in_a_o     (in_a),
    .in_b_o     (in_b),
    .code_a_o   (code_a_o),
    .code_b_o   (code_b_o)
  );

  assign unused_ok = ^{pin_rise[3:2], pin_fall[2]};
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
  parameter int DATA_W = 12,
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              commit,
  input logic [WORD_W-1:0] word,
  input logic              load_low,
  input logic              load_fall,
  input logic              solo,
  input logic              sdo_o,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic [DATA_W-1:0] code_a_o,
  input logic [DATA_W-1:0] code_b_o
);
  logic [3:0] cmd;
  logic       quiet, no_code_cmd, li_cmd;
  assign cmd         = word[WORD_W-1 -: 4];
  assign quiet       = !load_low && !load_fall;
  assign no_code_cmd = cmd inside {4'h0, 4'h2, 4'h5, 4'hA, 4'hD, 4'hE, 4'hF};
  assign li_cmd      = cmd inside {4'h3, 4'h6, 4'h8};

  p_lu_a_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && cmd == 4'h1 |=> code_a_o == $past(word[DATA_W-1:0]));
  p_lu_b_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && cmd == 4'h4 |=> code_b_o == $past(word[DATA_W-1:0]));
  p_li_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && li_cmd && quiet |=> $stable(code_a_o) && $stable(code_b_o));
  p_update_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && cmd == 4'h7 |=> code_a_o == $past(in_a) && code_b_o == $past(in_b));
  p_clear_mid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && cmd == 4'hC |=> code_a_o == 12'h800 && code_b_o == 12'h800);
  p_clear_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && cmd == 4'hB |=> code_a_o == '0 && code_b_o == '0);
  p_no_code_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && no_code_cmd && quiet |=> $stable(code_a_o) && $stable(code_b_o));
  p_load_pin_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_fall && !commit |=> code_a_o == $past(in_a) && code_b_o == $past(in_b));
  p_solo_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo |=> solo);
  p_solo_sdo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo |=> !sdo_o);
endmodule

bind dac_serial_front dacfe_checker #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .commit   (commit),
  .word     (word),
  .load_low (!pin_q[3]),
  .load_fall(pin_fall[3]),
  .solo     (solo),
  .sdo_o    (sdo_o),
  .in_a     (in_a),
  .in_b     (in_b),
  .code_a_o (code_a_o),
  .code_b_o (code_b_o)
);

// File: tb/dac_serial_front_tb_top.sv
module dac_serial_front_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, sclk = 1'b0, sdi = 1'b0, load_n = 1'b1;
  logic sdo, last_sdo, sdo_seen;
  logic [11:0] code_a, code_b;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  dac_serial_front dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .sclk_i(sclk), .sdi_i(sdi),
    .load_ni(load_n), .sdo_o(sdo), .code_a_o(code_a), .code_b_o(code_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sclk = 1'b1; sdi = b;
    wait_n(4);
    last_sdo = sdo;
    if (sdo) sdo_seen = 1'b1;
    sclk = 1'b0;
    wait_n(4);
  endtask

  task automatic bits_out(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) bit_out(w[15-i]);
  endtask

  task automatic frame_open();
    frame_n = 1'b0; wait_n(4);
  endtask

  task automatic frame_close();
    frame_n = 1'b1; wait_n(8);
  endtask

  task automatic send(input logic [15:0] w);
    frame_open(); bits_out(w, 16); frame_close();
  endtask

  task automatic pulse_load();
    load_n = 1'b0; wait_n(6); load_n = 1'b1; wait_n(6);
  endtask

  task automatic t_reset();
    chk("R2 code_a", code_a, 0);
    chk("R2 code_b", code_b, 0);
    chk("R2 sdo", sdo, 0);
  endtask

  task automatic t_load_update();
    send(16'h11AB);
    chk("R7 R1 load+update A", code_a, 12'h1AB);
    send(16'h6321);
    chk("R8 load input B keeps code", code_b, 0);
    pulse_load();
    chk("R12 load pin B", code_b, 12'h321);
    chk("R12 load pin A", code_a, 12'h1AB);
  endtask

  task automatic t_chain();
    logic [31:0] got = '0;
    frame_open();
    for (int i = 0; i < 32; i++) begin
      bit_out(((i < 16) ? 16'h4555 : 16'h10F0) >> (15 - (i % 16)));
      got = {got[30:0], last_sdo};
    end
    frame_close();
    chk("R4 chain sdo", got, {16'h0, 16'h4555});
    chk("R3 last word A", code_a, 12'h0F0);
    chk("R3 earlier word dropped", code_b, 12'h321);
  endtask

  task automatic t_noop();
    send(16'h0FFF); send(16'h2ABC); send(16'hFABC); send(16'hE123); send(16'h5111);
    chk("R11 noops A", code_a, 12'h0F0);
    chk("R11 noops B", code_b, 12'h321);
  endtask

  task automatic t_short();
    frame_open(); bits_out(16'h1777, 8); frame_close();
    chk("R3 short frame", code_a, 12'h0F0);
  endtask

  task automatic t_both_update();
    send(16'h8234);
    chk("R8 load both inputs", {code_a, code_b}, {12'h0F0, 12'h321});
    send(16'h7000);
    chk("R9 update both", {code_a, code_b}, {12'h234, 12'h234});
  endtask

  task automatic t_clear();
    send(16'hC000);
    chk("R10 midscale", {code_a, code_b}, {12'h800, 12'h800});
    send(16'hB000);
    chk("R10 zero", {code_a, code_b}, 0);
    pulse_load();
    chk("R10 inputs cleared", {code_a, code_b}, 0);
  endtask

  task automatic t_collide();
    frame_open(); bits_out(16'h3777, 16);
    frame_n = 1'b1; load_n = 1'b0;
    wait_n(8);
    chk("R12 collision A", code_a, 12'h777);
    chk("R12 collision B", code_b, 0);
    load_n = 1'b1; wait_n(6);
  endtask

  task automatic t_auto_chain();
    load_n = 1'b0; wait_n(6);
    send(16'h6ABC);
    chk("R13 auto chain B", code_b, 12'hABC);
    load_n = 1'b1; wait_n(6);
  endtask

  task automatic t_solo();
    send(16'h9000);
    chk("R5 mode cmd no code change", {code_a, code_b}, {12'h777, 12'hABC});
    sdo_seen = 1'b0;
    frame_open(); bits_out(16'h1456, 16);
    chk("R6 commit on 16th fall", code_a, 12'h456);
    bits_out(16'h1FFF, 16);
    frame_close();
    chk("R6 extra clocks ignored", code_a, 12'h456);
    frame_open(); bits_out(16'h1999, 8); frame_close();
    chk("R6 abort", code_a, 12'h456);
    send(16'h4111);
    chk("R6 after abort", code_b, 12'h111);
    chk("R5 sdo low solo", sdo_seen, 0);
  endtask

  task automatic t_solo_load();
    load_n = 1'b0; wait_n(6);
    frame_open(); bits_out(16'h3CDE, 16);
    chk("R13 auto solo A", code_a, 12'hCDE);
    frame_close();
    load_n = 1'b1; wait_n(6);
    send(16'h6246);
    chk("R8 solo input B", code_b, 12'h111);
    pulse_load();
    chk("R12 solo load pin", code_b, 12'h246);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    sdo_seen = 1'b0; last_sdo = 1'b0;
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(4);
    t_load_update();
    t_chain();
    t_noop();
    t_short();
    t_both_update();
    t_clear();
    t_collide();
    t_auto_chain();
    t_solo();
    t_solo_load();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule